// File: doc/BRIEF.md
# TDM Slot Receiver with Frame-Sync Checking

This block is the receive half of a time-division-multiplexed serial link built from 8-bit slots. A bit clock, a frame sync and a serial data line come either from the external bus (slave) or from a local clock generator (master). The three lines are oversampled in the system clock. The block takes each data bit on a programmable bit-clock edge, counted from the frame sync, and keeps only the bits that fall in enabled slots. It then packs the captured bytes into 16-bit words and presents them on a valid/ready stream.

The block also checks the frame timing. When a frame sync arrives anywhere other than the bit position where the next frame is due, it sets a sticky status flag and realigns its slot counter to the new frame. The flag drives a maskable interrupt. When a finished word finds the output register still occupied, the word is dropped and a sticky overflow flag is set.

Top module: `tdm_slot_rx`

## Requirements
- R1: With `cfg_master`=0 the bit clock and frame sync are taken from `bus_bclk`/`bus_fs`. With `cfg_master`=1 they are taken from `loc_bclk`/`loc_fs`. The unselected pair has no effect.
- R2: `cfg_smp` (bit 2 is the extension bit, bits 1:0 the base field) picks the bit-clock edge, counted from a frame sync, on which frame bit 0 is sampled. Edges alternate rising/falling, starting with the first rising edge. Code 0 selects the 2nd rising edge, 1 the 2nd falling, 2 the 3rd rising, 3 the 3rd falling and 4 the 4th rising. Codes 5, 6 and 7 select the 1st rising edge. Each later bit is sampled two edges after the previous bit.
- R3: Frame bit n belongs to slot n/8, and each slot carries its byte MSB first. Slot s is captured only when its enable bit is 1: slots 0–31 use `cfg_mask_lo[s]` and slots 32–63 use `cfg_mask_hi[s-32]`. Slots 64 and above are never captured. Disabled slots contribute nothing to the output.
- R4: A frame is `cfg_slots`×8 bits long. A frame sync arriving exactly that many rising bit-clock edges after the previous one is expected. It leaves the bit alignment and any partly assembled word untouched, and it does not set `irq_sts`.
- R5: Captured bytes are packed two per output word in arrival order. With `cfg_swap`=0 the earlier byte lands in bits 15:8. With `cfg_swap`=1 it lands in bits 7:0.
- R6: The first frame sync after reset aligns the receiver without setting a flag. Any later frame sync that is not expected sets `irq_sts` to 1. It also discards the partial word and restarts capture at bit 0 of slot 0 of the new frame.
- R7: `irq` is 1 exactly when `irq_sts` and `cfg_irq_en` are both 1. A pulse on `irq_clr` clears `irq_sts`.
- R8: Once `out_valid` is 1, it stays 1 and `out_data` stays stable until a cycle with `out_ready`=1.
- R9: A word that completes while `out_valid`=1 and `out_ready`=0 is discarded, and the held word is kept. This sets the sticky `ovf` flag, which is cleared by a pulse on `ovf_clr`.
- R10: After reset, `out_valid`, `irq`, `irq_sts` and `ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | Clock source select: 0 external bus, 1 local generator |
| cfg_slots | input | 7 | Slots per frame |
| cfg_smp | input | 3 | Sample-edge code |
| cfg_mask_lo | input | 32 | Enables for slots 0–31 |
| cfg_mask_hi | input | 32 | Enables for slots 32–63 |
| cfg_swap | input | 1 | Byte order of output words |
| cfg_irq_en | input | 1 | Interrupt enable, 1 passes `irq_sts` to `irq` |
| irq_clr | input | 1 | Clears `irq_sts` |
| ovf_clr | input | 1 | Clears `ovf` |
| bus_bclk | input | 1 | Bit clock from the bus |
| bus_fs | input | 1 | Frame sync from the bus |
| loc_bclk | input | 1 | Bit clock from the local generator |
| loc_fs | input | 1 | Frame sync from the local generator |
| sdin | input | 1 | Serial receive data |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 16 | Received word |
| irq | output | 1 | Masked unexpected-frame-sync interrupt |
| irq_sts | output | 1 | Sticky unexpected-frame-sync status |
| ovf | output | 1 | Sticky dropped-word flag |

## Verification
The assertions assume that each bit-clock half period lasts several system clocks. They also assume that the frame sync and the data line change only midway through a half period, so that no frame-sync rise coincides with a bit-clock edge in the oversampled view. The stimulus generator produces every edge on a four-cycle half period. It moves data and frame sync two cycles before each edge, keeping every run inside those assumptions. The configuration inputs are changed only while the receiver is held in reset or is idle between frames.

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int SLOT_W     = 7,
  parameter int WORD_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_master,
  input  logic [SLOT_W-1:0]       cfg_slots,
  input  logic [2:0]              cfg_smp,
  input  logic [31:0]             cfg_mask_lo,
  input  logic [31:0]             cfg_mask_hi,
  input  logic                    cfg_swap,
  input  logic                    cfg_irq_en,
  input  logic                    irq_clr,
  input  logic                    ovf_clr,
  input  logic                    bus_bclk,
  input  logic                    bus_fs,
  input  logic                    loc_bclk,
  input  logic                    loc_fs,
  input  logic                    sdin,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [8*WORD_BYTES-1:0] out_data,
  output logic                    irq,
  output logic                    irq_sts,
  output logic                    ovf
);
  localparam int BIT_W  = SLOT_W + 3;
  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int BC_W   = $clog2(WORD_BYTES);

  logic s_bclk, p_bclk, s_fs, p_fs, s_din;
  logic locked, ph;
  logic [BIT_W-1:0] rcnt, bitpos;
  logic [2:0] dly, off;
  logic [6:0] sr;
  logic [WORD_W-1:0] acc;
  logic [BC_W-1:0] bcnt;

  wire [BIT_W-1:0] fbits = {cfg_slots, 3'b000};
  wire rise     = s_bclk & ~p_bclk;
  wire edge_any = s_bclk ^ p_bclk;
  wire fs_ev    = s_fs & ~p_fs;
  wire fs_bad   = fs_ev && locked && (rcnt != fbits);
  wire realign  = fs_ev && (!locked || fs_bad);
  wire smp      = locked && !realign && edge_any && (dly == 3'd0) && !ph;

  wire [SLOT_W-1:0] slot = bitpos[BIT_W-1:3];
  wire slot_en = (slot[SLOT_W-1:5] == '0)                 ? cfg_mask_lo[slot[4:0]] :
                 (slot[SLOT_W-1:5] == (SLOT_W-5)'(1))     ? cfg_mask_hi[slot[4:0]] : 1'b0;

  wire [7:0] new_byte = {sr, s_din};
  wire byte_done = smp && slot_en && (bitpos[2:0] == 3'd7);
  wire word_done = byte_done && (bcnt == BC_W'(WORD_BYTES - 1));
  wire [WORD_W-1:0] acc_nxt = cfg_swap ? {new_byte, acc[WORD_W-1:8]} : {acc[WORD_W-9:0], new_byte};

  always_comb begin
    case (cfg_smp)
      3'd0: off = 3'd2;
      3'd1: off = 3'd3;
      3'd2: off = 3'd4;
      3'd3: off = 3'd5;
      3'd4: off = 3'd6;
      default: off = 3'd0;
    endcase
  end

  assign irq = irq_sts & cfg_irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_bclk <= 1'b0; p_bclk <= 1'b0; s_fs <= 1'b0; p_fs <= 1'b0; s_din <= 1'b0;
    end else begin
      s_bclk <= cfg_master ? loc_bclk : bus_bclk;
      s_fs   <= cfg_master ? loc_fs : bus_fs;
      s_din  <= sdin;
      p_bclk <= s_bclk;
      p_fs   <= s_fs;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0; ph <= 1'b0; dly <= '0; rcnt <= '0; bitpos <= '0;
      sr <= '0; acc <= '0; bcnt <= '0;
    end else if (realign) begin
      locked <= 1'b1; ph <= 1'b0; dly <= off; rcnt <= '0; bitpos <= '0; bcnt <= '0;
    end else begin
      if (fs_ev) rcnt <= '0;
      else if (rise && rcnt != '1) rcnt <= rcnt + BIT_W'(1);
      if (locked && edge_any) begin
        if (dly != 3'd0) dly <= dly - 3'd1;
        else begin
          ph <= ~ph;
          if (!ph) begin
            bitpos <= (bitpos == fbits - BIT_W'(1)) ? '0 : bitpos + BIT_W'(1);
            if (slot_en) sr <= {sr[5:0], s_din};
            if (byte_done) begin
              acc  <= acc_nxt;
              bcnt <= word_done ? '0 : bcnt + BC_W'(1);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; ovf <= 1'b0; irq_sts <= 1'b0;
    end else begin
      if (word_done && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_data  <= acc_nxt;
      end else if (out_ready) out_valid <= 1'b0;
      if (word_done && out_valid && !out_ready) ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
      if (fs_bad) irq_sts <= 1'b1;
      else if (irq_clr) irq_sts <= 1'b0;
    end
  end

  p_bad_fs_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_ev && locked && rcnt != fbits) |=> irq_sts);
  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_valid_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(out_valid && !out_ready));
  p_good_fs_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_ev && locked && rcnt == fbits && !irq_sts) |=> !irq_sts);
endmodule

// File: tb/tdm_slot_rx_tb.sv
module tdm_slot_rx_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_swap = 1'b0, cfg_irq_en = 1'b1, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [6:0] cfg_slots = 7'd4;
  logic [2:0] cfg_smp = 3'd0;
  logic [31:0] cfg_mask_lo = 32'h0, cfg_mask_hi = 32'h0;
  logic b_l = 1'b0, f_l = 1'b0, sdin = 1'b0, out_ready = 1'b1;
  logic out_valid, irq, irq_sts, ovf;
  logic [15:0] out_data;

  wire bus_bclk = cfg_master ? 1'b0 : b_l;
  wire bus_fs   = cfg_master ? 1'b0 : f_l;
  wire loc_bclk = cfg_master ? b_l : 1'b0;
  wire loc_fs   = cfg_master ? f_l : 1'b0;

  tdm_slot_rx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_slots(cfg_slots), .cfg_smp(cfg_smp),
    .cfg_mask_lo(cfg_mask_lo), .cfg_mask_hi(cfg_mask_hi), .cfg_swap(cfg_swap), .cfg_irq_en(cfg_irq_en),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .bus_bclk(bus_bclk), .bus_fs(bus_fs), .loc_bclk(loc_bclk),
    .loc_fs(loc_fs), .sdin(sdin), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .irq(irq), .irq_sts(irq_sts), .ovf(ovf));

  // master, code, swap, slots, mask_hi, mask_lo
  localparam logic [75:0] VEC [9] = '{
    {1'b0, 3'd0, 1'b0, 7'd4,  32'h0, 32'hF},
    {1'b0, 3'd1, 1'b1, 7'd4,  32'h0, 32'h5},
    {1'b0, 3'd2, 1'b0, 7'd4,  32'h0, 32'hB},
    {1'b0, 3'd3, 1'b1, 7'd3,  32'h0, 32'h7},
    {1'b0, 3'd4, 1'b0, 7'd4,  32'h0, 32'hE},
    {1'b1, 3'd5, 1'b1, 7'd4,  32'h0, 32'hF},
    {1'b0, 3'd6, 1'b0, 7'd2,  32'h0, 32'h3},
    {1'b1, 3'd7, 1'b1, 7'd36, 32'h8, 32'h1},
    {1'b0, 3'd2, 1'b0, 7'd70, 32'hFFFFFFFF, 32'hFFFFFFFF}
  };

  int checks = 0, failures = 0, seed = 0, nrec = 0;
  logic [15:0] rec [128];
  logic [15:0] expw [128];
  int nexp;

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && nrec < 128) begin
      rec[nrec] = out_data;
      nrec++;
    end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic logic [7:0] byte_of(input int g);
    return 8'((g * 53 + seed * 17 + 11) & 255);
  endfunction

  function automatic logic bit_of(input int m);
    logic [7:0] b = byte_of(m / 8);
    return b[7 - (m % 8)];
  endfunction

  function automatic int off_of(input logic [2:0] c);
    case (c)
      3'd0: return 2; 3'd1: return 3; 3'd2: return 4; 3'd3: return 5; 3'd4: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; b_l = 1'b0; f_l = 1'b0; sdin = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; nrec = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int np);
    int fb = int'(cfg_slots) * 8;
    int off = off_of(cfg_smp);
    for (int e = 0; e < 2 * np; e++) begin
      repeat (2) @(negedge clk);
      if (e >= off && ((e - off) % 2) == 0) sdin = bit_of((e - off) / 2);
      if (e % 2 == 0) f_l = ((e / 2) % fb) == 0;
      repeat (2) @(negedge clk);
      b_l = (e % 2 == 0);
    end
    repeat (20) @(negedge clk);
  endtask

  task automatic build_exp(input int frames);
    int nb = 0;
    logic [7:0] first = 8'h0;
    nexp = 0;
    for (int g = 0; g < frames * int'(cfg_slots); g++) begin
      int s = g % int'(cfg_slots);
      logic en = (s < 32) ? cfg_mask_lo[s] : (s < 64) ? cfg_mask_hi[s - 32] : 1'b0;
      if (en) begin
        if (nb % 2 == 0) first = byte_of(g);
        else if (nexp < 128) begin
          expw[nexp] = cfg_swap ? {byte_of(g), first} : {first, byte_of(g)};
          nexp++;
        end
        nb++;
      end
    end
  endtask

  task automatic cmp_words(input string tag);
    chk(nrec >= nexp, {tag, " word count"}, nrec, nexp);
    for (int i = 0; i < nexp && i < nrec; i++)
      chk(rec[i] === expw[i], tag, rec[i], expw[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R10 reset state
    chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(irq_sts == 1'b0, "R10 irq_sts", irq_sts, 0);
    chk(ovf == 1'b0, "R10 ovf", ovf, 0);

    // R1 R2 R3 R4 R5: table of configurations
    for (int v = 0; v < 9; v++) begin
      {cfg_master, cfg_smp, cfg_swap, cfg_slots, cfg_mask_hi, cfg_mask_lo} = VEC[v];
      seed = v;
      out_ready = 1'b1;
      do_reset();
      run(3 * int'(cfg_slots) * 8);
      build_exp(2);
      cmp_words($sformatf("R1 R2 R3 R5 vec%0d", v));
      chk(irq_sts == 1'b0, $sformatf("R4 no flag on expected sync vec%0d", v), irq_sts, 0);
      chk(ovf == 1'b0, $sformatf("R9 no overflow with ready vec%0d", v), ovf, 0);
    end

    // R6 R7: early frame sync realigns and flags
    {cfg_master, cfg_smp, cfg_swap, cfg_slots, cfg_mask_hi, cfg_mask_lo} = VEC[0];
    cfg_irq_en = 1'b1;
    seed = 20;
    do_reset();
    run(20);
    chk(irq_sts == 1'b0, "R6 first sync not flagged", irq_sts, 0);
    nrec = 0;
    run(96);
    chk(irq_sts == 1'b1, "R6 early sync flagged", irq_sts, 1);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
    build_exp(2);
    cmp_words("R6 realigned words");
    cfg_irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    chk(irq_sts == 1'b1, "R7 status kept while masked", irq_sts, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
    chk(irq_sts == 1'b0, "R7 status cleared", irq_sts, 0);

    // R8 R9: stalled consumer
    cfg_irq_en = 1'b1;
    seed = 30;
    do_reset();
    @(posedge clk); #1 out_ready = 1'b0;
    run(96);
    build_exp(1);
    chk(out_valid == 1'b1, "R8 word held", out_valid, 1);
    chk(out_data == expw[0], "R8 held data is first word", out_data, expw[0]);
    chk(ovf == 1'b1, "R9 overflow set", ovf, 1);
    chk(nrec == 0, "R8 nothing taken while stalled", nrec, 0);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(nrec == 1 && rec[0] == expw[0], "R9 first word kept", rec[0], expw[0]);
    chk(out_valid == 1'b0, "R8 valid drops after handshake", out_valid, 0);
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
    chk(ovf == 1'b0, "R9 overflow cleared", ovf, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule